// File: doc/BRIEF.md
# Prioritized Interrupt Distributor

This block collects interrupt requests from software and from external lines. It selects the most urgent request and signals one processor through a single interrupt output. Each source keeps its own state: an enable bit, a pending bit, an active bit, a sampled line level, a configuration pair (model bit and edge-trigger bit) and an 8-bit priority. A lower priority value means more urgent. The processor reaches the block over one synchronous register bus. Address bit 12 selects between two banks. The bank with bit 12 set is the distributor, which holds the per-source state. The bank with bit 12 clear is the processor interface, which handles the mask, acknowledge, completion and running priority.

The processor takes an interrupt by reading the acknowledge register, and this read raises the running priority. A more urgent source can then preempt the running one, and the block records each preemption in a per-source predecessor link. A completion write normally retires the running interrupt, which restores its predecessor. It may also retire an interrupt deeper in the chain, which is then unlinked while the running one is left alone. External line k is source ID 32+k. ID 1023 stands for "nothing".

Top module: `irq_distributor`

## Requirements
- R1: After reset the following hold. Both enables are off and the mask reads 0xF0. The running priority reads 0x100 and the highest pending ID reads 1023. The interrupt output and error flag are low. IDs 0 to 14 are enabled and edge-triggered, so the enable word at distributor 0x100 reads 0x00007FFF and the configuration word at 0xC00 reads 0x2AAAAAAA. All other per-source state is zero.
- R2: Among sources that are both enabled and pending, the one with the lowest priority value wins, and a tie goes to the lowest ID. The CPU-bank register at 0x18 shows the winner when its priority is at or below the mask (CPU 0x04, low 10 bits kept), and 1023 otherwise. The interrupt output is high only when that winner's priority is also strictly below the running priority.
- R3: When the distributor enable (distributor 0x000 bit 0) or the processor enable (CPU 0x00 bit 0) is 0, the output is low and CPU 0x18 reads 1023.
- R4: A read of CPU 0x0C while the output is high does the following. It returns the winner and clears that winner's pending bit. It sets the winner's active bit, which is readable at distributor 0x300 with bit n%32 of word n/32. It links the previously running ID as the winner's predecessor, and the winner's priority becomes the running priority (CPU 0x14). Otherwise the read returns 1023 and changes nothing.
- R5: A write to CPU 0x10 whose low 10 bits equal the running ID retires that ID. Its predecessor becomes running with the predecessor's priority, or 1023 with priority 0x100 when there is no predecessor.
- R6: A write to CPU 0x10 naming an active ID that is not running removes that ID from the predecessor chain and clears its active bit, and the running ID and priority stay as they were.
- R7: A write to CPU 0x10 while the running ID is 1023 has no effect.
- R8: External line k drives ID 32+k. A rising line sets pending when the source is edge-triggered or enabled. Setting the enable of a level source whose line is high sets pending. When a level source is retired while it is enabled and its line is still high, it becomes pending again.
- R9: Distributor words at 0x100, 0x180, 0x200 and 0x280 set enables, clear enables, set pending and clear pending. Bit b of word n acts on ID 32n+b, and reading the word returns the current bits.
- R10: The byte at 0x400+id holds that source's priority. The configuration word at 0xC00 holds 2 bits per source, with ID 16n+j at bits 2j (model) and 2j+1 (edge trigger) of word n. Target bytes at 0x800+id always read 0x01.
- R11: A write to distributor 0xF00 with byte lanes 0 and 1 both enabled sets pending for the ID in bits 9:0.
- R12: Distributor 0x004 reads NUM_IRQ/32-1. Word 0xFE0+4k returns byte k of the IDENT parameter.
- R13: An access to an undefined offset reads 0 and writes nothing. It also sets an error flag that stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lines_i | input | NUM_IRQ-32 | External interrupt lines, line k is ID 32+k |
| addr_i | input | 13 | Byte address; bit 12 selects the distributor bank |
| re_i | input | 1 | Read strobe |
| we_i | input | 1 | Write strobe |
| be_i | input | 4 | Byte lane enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Interrupt request to the processor |
| err_o | output | 1 | Sticky undefined-access flag |

## Verification
The bench builds the block with NUM_IRQ set to 64. This gives two 32-bit groups and 32 external lines, so a source in the second group and any line can be reached with short register sequences. With only two groups, the third set-enable word (0x108) is already undefined, which makes the region boundaries easy to probe. Random rounds use priorities that are multiples of 0x20 so that ties and mask boundaries occur often. Directed sequences cover a three-deep preemption chain, retiring out of order, and the re-pending of a level source.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [9:0] ID_NONE = 10'd1023;
  localparam logic [8:0] PRIO_IDLE = 9'h100;

  // distributor word indices (byte offset / 4)
  localparam int W_CTRL   = 0;
  localparam int W_INFO   = 1;
  localparam int W_SETEN  = 64;
  localparam int W_CLREN  = 96;
  localparam int W_SETPD  = 128;
  localparam int W_CLRPD  = 160;
  localparam int W_ACTV   = 192;
  localparam int W_PRIO   = 256;
  localparam int W_TGT    = 512;
  localparam int W_CFG    = 768;
  localparam int W_SWTRIG = 960;
  localparam int W_IDENT  = 1016;

  // processor interface word indices
  localparam int C_CTRL  = 0;
  localparam int C_MASK  = 1;
  localparam int C_BINPT = 2;
  localparam int C_ACK   = 3;
  localparam int C_EOI   = 4;
  localparam int C_RUN   = 5;
  localparam int C_HPEND = 6;
  localparam int C_WORDS = 7;

  function automatic logic in_rng(input logic [9:0] w, input int base, input int cnt);
    return (int'(w) >= base) && (int'(w) < base + cnt);
  endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_IRQ = 96
) (
  input  logic [NUM_IRQ-1:0]   cand_i,
  input  logic [8*NUM_IRQ-1:0] prio_i,
  output logic                 vld_o,
  output logic [9:0]           id_o,
  output logic [7:0]           prio_o
);
  localparam int LVL = $clog2(NUM_IRQ);
  localparam int P   = 1 << LVL;

  logic       n_vld [2*P];
  logic [9:0] n_id  [2*P];
  logic [7:0] n_pr  [2*P];

  // heap-ordered tree: left child holds lower IDs, so ties go left
  always_comb begin
    for (int k = 0; k < 2*P; k++) begin
      n_vld[k] = 1'b0;
      n_id[k]  = '0;
      n_pr[k]  = '0;
    end
    for (int i = 0; i < NUM_IRQ; i++) begin
      n_vld[P+i] = cand_i[i];
      n_id[P+i]  = 10'(i);
      n_pr[P+i]  = prio_i[8*i +: 8];
    end
    for (int k = P-1; k >= 1; k--) begin
      if (n_vld[2*k] && (!n_vld[2*k+1] || n_pr[2*k] <= n_pr[2*k+1])) begin
        n_vld[k] = 1'b1;
        n_id[k]  = n_id[2*k];
        n_pr[k]  = n_pr[2*k];
      end else begin
        n_vld[k] = n_vld[2*k+1];
        n_id[k]  = n_id[2*k+1];
        n_pr[k]  = n_pr[2*k+1];
      end
    end
  end

  assign vld_o  = n_vld[1];
  assign id_o   = n_id[1];
  assign prio_o = n_pr[1];
endmodule

// File: rtl/irq_source.sv
module irq_source #(
  parameter bit RST_ON = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  logic       set_en_i,
  input  logic       clr_en_i,
  input  logic       set_pend_i,
  input  logic       clr_pend_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_i,
  input  logic       prio_we_i,
  input  logic [7:0] prio_i,
  input  logic       ack_i,
  input  logic       eoi_i,
  input  logic       link_we_i,
  input  logic [9:0] link_i,
  output logic       en_o,
  output logic       pend_o,
  output logic       act_o,
  output logic [1:0] cfg_o,
  output logic [7:0] prio_o,
  output logic [9:0] prev_o
);
  logic lvl_q, model_q, trig_q;
  logic pend_set, pend_clr;

  assign pend_set = set_pend_i
                  | (line_i & ~lvl_q & (trig_q | en_o))
                  | (set_en_i & lvl_q & ~trig_q)
                  | (eoi_i & ~trig_q & en_o & lvl_q);
  assign pend_clr = clr_pend_i | ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= 1'b0;
      en_o    <= RST_ON;
      trig_q  <= RST_ON;
      model_q <= 1'b0;
      pend_o  <= 1'b0;
      act_o   <= 1'b0;
      prio_o  <= '0;
      prev_o  <= 10'd1023;
    end else begin
      lvl_q <= line_i;
      if (set_en_i)      en_o <= 1'b1;
      else if (clr_en_i) en_o <= 1'b0;
      if (cfg_we_i) {trig_q, model_q} <= cfg_i;
      if (prio_we_i) prio_o <= prio_i;
      if (pend_set)      pend_o <= 1'b1;
      else if (pend_clr) pend_o <= 1'b0;
      if (ack_i)      act_o <= 1'b1;
      else if (eoi_i) act_o <= 1'b0;
      if (link_we_i) prev_o <= link_i;
    end
  end

  assign cfg_o = {trig_q, model_q};

  a_r9_set_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> en_o);
  a_r8_edge_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i && !lvl_q && trig_q) |=> pend_o);
  a_r4_ack_marks_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> (act_o && !$past(eoi_i)));
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irq_dist_pkg::*;
#(
  parameter int          NUM_IRQ = 96,
  parameter logic [63:0] IDENT   = 64'hC3_5A_21_07_9E_44_18_B6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_IRQ-33:0] lines_i,
  input  logic [12:0]         addr_i,
  input  logic                re_i,
  input  logic                we_i,
  input  logic [3:0]          be_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  output logic                irq_o,
  output logic                err_o
);
  localparam int GROUPS    = NUM_IRQ / 32;
  localparam int PRIO_WDS  = NUM_IRQ / 4;
  localparam int CFG_WDS   = NUM_IRQ / 16;
  localparam int RST_ON_LO = 15;

  logic [9:0] w;
  logic       wr_d, wr_c, rd_c;
  assign w    = addr_i[11:2];
  assign wr_d = we_i & addr_i[12];
  assign wr_c = we_i & ~addr_i[12];
  assign rd_c = re_i & ~addr_i[12];

  logic [NUM_IRQ-1:0]   en_v, pend_v, act_v;
  logic [2*NUM_IRQ-1:0] cfg_flat;
  logic [8*NUM_IRQ-1:0] prio_flat;
  logic [9:0]           prev_a [NUM_IRQ];

  logic       dist_en_q, cpu_en_q;
  logic [9:0] mask_q, run_id_q;
  logic [8:0] run_prio_q;
  logic       best_vld_q;
  logic [9:0] best_id_q;
  logic [7:0] best_prio_q;
  logic       err_q;
  logic [31:0] rdata_q;

  logic       arb_vld;
  logic [9:0] arb_id;
  logic [7:0] arb_prio;

  irq_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .cand_i (en_v & pend_v),
    .prio_i (prio_flat),
    .vld_o  (arb_vld),
    .id_o   (arb_id),
    .prio_o (arb_prio)
  );

  logic       hp_vld;
  logic [9:0] hp_id;
  assign hp_vld = dist_en_q & cpu_en_q & best_vld_q & ({2'b0, best_prio_q} <= mask_q);
  assign hp_id  = hp_vld ? best_id_q : ID_NONE;
  assign irq_o  = hp_vld & ({1'b0, best_prio_q} < run_prio_q);

  logic       ack_go, eoi_fire, eoi_run, eoi_splice;
  logic [9:0] eoi_id, eoi_prev;
  logic [7:0] prev_prio;
  assign ack_go     = rd_c & (int'(w) == C_ACK) & irq_o;
  assign eoi_id     = wdata_i[9:0];
  assign eoi_fire   = wr_c & (int'(w) == C_EOI) & (run_id_q != ID_NONE);
  assign eoi_run    = eoi_fire & (eoi_id == run_id_q);
  assign eoi_splice = eoi_fire & ~eoi_run & (eoi_id != ID_NONE);

  always_comb begin
    eoi_prev  = ID_NONE;
    prev_prio = '0;
    for (int i = 0; i < NUM_IRQ; i++)
      if (eoi_id == 10'(i)) eoi_prev = prev_a[i];
    for (int i = 0; i < NUM_IRQ; i++)
      if (eoi_prev == 10'(i)) prev_prio = prio_flat[8*i +: 8];
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
    localparam int G = i / 32;
    localparam int B = i % 32;
    localparam int J = i % 16;
    logic line, ack_s, splice_s;
    if (i >= 32) begin : g_line
      assign line = lines_i[i-32];
    end else begin : g_noline
      assign line = 1'b0;
    end
    assign ack_s    = ack_go & (best_id_q == 10'(i));
    assign splice_s = eoi_splice & act_v[i] & (prev_a[i] == eoi_id);

    irq_source #(.RST_ON(i < RST_ON_LO)) u_src (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .line_i     (line),
      .set_en_i   (wr_d & (w == 10'(W_SETEN + G)) & be_i[B/8] & wdata_i[B]),
      .clr_en_i   (wr_d & (w == 10'(W_CLREN + G)) & be_i[B/8] & wdata_i[B]),
      .set_pend_i ((wr_d & (w == 10'(W_SETPD + G)) & be_i[B/8] & wdata_i[B])
                   | (wr_d & (w == 10'(W_SWTRIG)) & (&be_i[1:0]) & (wdata_i[9:0] == 10'(i)))),
      .clr_pend_i (wr_d & (w == 10'(W_CLRPD + G)) & be_i[B/8] & wdata_i[B]),
      .cfg_we_i   (wr_d & (w == 10'(W_CFG + i/16)) & be_i[J/4]),
      .cfg_i      (wdata_i[2*J +: 2]),
      .prio_we_i  (wr_d & (w == 10'(W_PRIO + i/4)) & be_i[i%4]),
      .prio_i     (wdata_i[8*(i%4) +: 8]),
      .ack_i      (ack_s),
      .eoi_i      (eoi_fire & (eoi_id == 10'(i))),
      .link_we_i  (ack_s | splice_s),
      .link_i     (ack_s ? run_id_q : eoi_prev),
      .en_o       (en_v[i]),
      .pend_o     (pend_v[i]),
      .act_o      (act_v[i]),
      .cfg_o      (cfg_flat[2*i +: 2]),
      .prio_o     (prio_flat[8*i +: 8]),
      .prev_o     (prev_a[i])
    );
  end

  logic        def_d, def_c;
  logic [31:0] rd_val;
  int          off;

  assign def_c = (int'(w) < C_WORDS) && (addr_i[11:2] == w);
  always_comb begin
    def_d  = 1'b0;
    rd_val = '0;
    off    = 0;
    if (addr_i[12]) begin
      if (int'(w) == W_CTRL) begin
        def_d = 1'b1; rd_val = {31'b0, dist_en_q};
      end else if (int'(w) == W_INFO) begin
        def_d = 1'b1; rd_val = 32'(GROUPS - 1);
      end else if (in_rng(w, W_SETEN, GROUPS) || in_rng(w, W_CLREN, GROUPS)) begin
        def_d = 1'b1; off = (int'(w) - W_SETEN) % 32; rd_val = en_v[off*32 +: 32];
      end else if (in_rng(w, W_SETPD, GROUPS) || in_rng(w, W_CLRPD, GROUPS)) begin
        def_d = 1'b1; off = (int'(w) - W_SETPD) % 32; rd_val = pend_v[off*32 +: 32];
      end else if (in_rng(w, W_ACTV, GROUPS)) begin
        def_d = 1'b1; off = int'(w) - W_ACTV; rd_val = act_v[off*32 +: 32];
      end else if (in_rng(w, W_PRIO, PRIO_WDS)) begin
        def_d = 1'b1; off = int'(w) - W_PRIO; rd_val = prio_flat[off*32 +: 32];
      end else if (in_rng(w, W_TGT, PRIO_WDS)) begin
        def_d = 1'b1; rd_val = 32'h0101_0101;
      end else if (in_rng(w, W_CFG, CFG_WDS)) begin
        def_d = 1'b1; off = int'(w) - W_CFG; rd_val = cfg_flat[off*32 +: 32];
      end else if (int'(w) == W_SWTRIG) begin
        def_d = 1'b1;
      end else if (int'(w) >= W_IDENT) begin
        def_d = 1'b1; off = int'(w) - W_IDENT; rd_val = {24'b0, IDENT[off*8 +: 8]};
      end
    end else begin
      case (int'(w))
        C_CTRL:  rd_val = {31'b0, cpu_en_q};
        C_MASK:  rd_val = {22'b0, mask_q};
        C_ACK:   rd_val = {22'b0, irq_o ? best_id_q : ID_NONE};
        C_RUN:   rd_val = {23'b0, run_prio_q};
        C_HPEND: rd_val = {22'b0, hp_id};
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dist_en_q   <= 1'b0;
      cpu_en_q    <= 1'b0;
      mask_q      <= 10'h0F0;
      run_id_q    <= ID_NONE;
      run_prio_q  <= PRIO_IDLE;
      best_vld_q  <= 1'b0;
      best_id_q   <= ID_NONE;
      best_prio_q <= '0;
      err_q       <= 1'b0;
      rdata_q     <= '0;
    end else begin
      best_vld_q  <= arb_vld;
      best_id_q   <= arb_vld ? arb_id : ID_NONE;
      best_prio_q <= arb_prio;
      if (wr_d && int'(w) == W_CTRL && be_i[0]) dist_en_q <= wdata_i[0];
      if (wr_c && int'(w) == C_CTRL) cpu_en_q <= wdata_i[0];
      if (wr_c && int'(w) == C_MASK) mask_q <= wdata_i[9:0];
      if (ack_go) begin
        run_id_q   <= best_id_q;
        run_prio_q <= {1'b0, best_prio_q};
      end else if (eoi_run) begin
        run_id_q   <= eoi_prev;
        run_prio_q <= (eoi_prev == ID_NONE) ? PRIO_IDLE : {1'b0, prev_prio};
      end
      if (re_i) rdata_q <= rd_val;
      if ((re_i || we_i) && !(addr_i[12] ? def_d : def_c)) err_q <= 1'b1;
    end
  end

  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  a_r4_ack_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_go |=> !irq_o);
  a_r4_ack_raises_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_go |=> (run_prio_q < $past(run_prio_q)));
  a_r5_eoi_reverts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_run |=> (run_id_q == $past(eoi_prev)));
  a_r6_splice_keeps_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_splice |=> $stable(run_id_q));
  a_r7_idle_eoi_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_c && int'(w) == C_EOI && run_id_q == ID_NONE) |=> (run_id_q == ID_NONE && $stable(act_v)));
  a_r2_irq_needs_candidate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(en_v & pend_v)));
endmodule

// File: tb/irq_distributor_test.sv
`timescale 1ns/1ps
module irq_distributor_test;
  localparam int N = 64;
  localparam logic [12:0] D = 13'h1000;
  localparam logic [63:0] IDV = 64'hC3_5A_21_07_9E_44_18_B6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-33:0] lines = '0;
  logic [12:0] addr = '0;
  logic re = 1'b0, we = 1'b0;
  logic [3:0] be = 4'hF;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, err;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  irq_distributor #(.NUM_IRQ(N), .IDENT(IDV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lines_i(lines), .addr_i(addr), .re_i(re),
    .we_i(we), .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .err_o(err)
  );

  bit       m_en [N];
  bit       m_pend [N];
  bit [7:0] m_prio [N];

  function automatic int exp_best(input int mask);
    int b = 1023;
    int bp = 256;
    for (int i = 0; i < N; i++)
      if (m_en[i] && m_pend[i] && int'(m_prio[i]) < bp) begin
        bp = int'(m_prio[i]); b = i;
      end
    if (bp > mask) b = 1023;
    return b;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; be = 4'hF; we = 1'b1;
    @(negedge clk); we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); d = rdata; re = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int e, m;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin m_en[i] = (i < 15); m_pend[i] = 0; m_prio[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(13'h004, v); chk("R1 mask", v, 32'hF0);
    rd(13'h014, v); chk("R1 running prio", v, 32'h100);
    rd(13'h018, v); chk("R1 hp id", v, 32'd1023);
    rd(D | 13'h100, v); chk("R1 enables", v, 32'h7FFF);
    rd(D | 13'hC00, v); chk("R1 config", v, 32'h2AAA_AAAA);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 err", {31'b0, err}, 0);

    wr(D, 1); wr(13'h000, 1);
    // R3 enables gate output
    wr(D | 13'h200, 32'h20);
    rd(13'h018, v); chk("R3 hp enabled", v, 5);
    chk("R3 irq enabled", {31'b0, irq}, 1);
    wr(D, 0);
    rd(13'h018, v); chk("R3 hp dist off", v, 32'd1023);
    chk("R3 irq dist off", {31'b0, irq}, 0);
    wr(D, 1); wr(13'h000, 0);
    chk("R3 irq cpu off", {31'b0, irq}, 0);
    wr(13'h000, 1);
    wr(D | 13'h280, 32'h20);

    // R2 tie and mask boundary, R10 priority bytes
    wr(D | 13'h428, 32'h0000_3030);
    rd(D | 13'h428, v); chk("R10 prio readback", v, 32'h0000_3030);
    wr(D | 13'h104, 32'h300);
    wr(D | 13'h204, 32'h300);
    rd(13'h018, v); chk("R2 tie lowest id", v, 40);
    wr(13'h004, 32'h30);
    rd(13'h018, v); chk("R2 prio equal mask", v, 40);
    chk("R2 irq equal mask", {31'b0, irq}, 1);
    wr(13'h004, 32'h2F);
    rd(13'h018, v); chk("R2 prio above mask", v, 32'd1023);
    chk("R2 irq above mask", {31'b0, irq}, 0);
    wr(13'h004, 32'hF0);
    wr(D | 13'h284, 32'h300);

    // R4 R5 R6 nesting: 44=0x80, 45=0x40, 46=0x60
    wr(D | 13'h42C, 32'h0060_4080);
    wr(D | 13'h104, 32'h7000);
    wr(D | 13'h204, 32'h1000);
    rd(13'h00C, v); chk("R4 ack id", v, 44);
    rd(13'h014, v); chk("R4 running prio", v, 32'h80);
    rd(D | 13'h204, v); chk("R4 pending cleared", v, 0);
    rd(D | 13'h304, v); chk("R4 active set", v, 32'h1000);
    wr(D | 13'h204, 32'h2000);
    rd(13'h00C, v); chk("R4 preempt ack", v, 45);
    rd(13'h014, v); chk("R4 nested prio", v, 32'h40);
    wr(D | 13'h204, 32'h4000);
    rd(13'h018, v); chk("R2 hp below mask", v, 46);
    chk("R2 irq blocked by running", {31'b0, irq}, 0);
    rd(13'h00C, v); chk("R4 spurious ack", v, 32'd1023);
    rd(13'h014, v); chk("R4 spurious no effect", v, 32'h40);
    wr(13'h010, 45);
    rd(13'h014, v); chk("R5 revert prio", v, 32'h80);
    chk("R5 irq after revert", {31'b0, irq}, 1);
    rd(13'h00C, v); chk("R4 ack third", v, 46);
    rd(D | 13'h304, v); chk("R4 active pair", v, 32'h5000);
    wr(13'h010, 44);
    rd(13'h014, v); chk("R6 running kept", v, 32'h60);
    rd(D | 13'h304, v); chk("R6 active after splice", v, 32'h4000);
    wr(13'h010, 46);
    rd(13'h014, v); chk("R6 chain skips spliced", v, 32'h100);
    rd(D | 13'h304, v); chk("R5 none active", v, 0);

    // R7 idle completion
    wr(13'h010, 44);
    rd(13'h014, v); chk("R7 idle eoi", v, 32'h100);
    rd(D | 13'h304, v); chk("R7 active unchanged", v, 0);
    rd(13'h00C, v); chk("R4 ack nothing", v, 32'd1023);

    // R8 lines: ID 35 edge (line 3), ID 36 level (line 4)
    wr(D | 13'hC08, 32'h80);
    rd(D | 13'hC08, v); chk("R10 config bits", v, 32'h80);
    @(negedge clk); lines[3] = 1'b1; lines[4] = 1'b1; settle();
    rd(D | 13'h204, v); chk("R8 edge pends, disabled level not", v, 32'h8);
    wr(D | 13'h104, 32'h10);
    rd(D | 13'h204, v); chk("R8 enable level high pends", v, 32'h18);
    wr(D | 13'h284, 32'h8);
    rd(13'h00C, v); chk("R8 ack level", v, 36);
    rd(D | 13'h204, v); chk("R8 ack clears level", v, 0);
    wr(13'h010, 36);
    rd(D | 13'h204, v); chk("R8 level re-pends", v, 32'h10);
    @(negedge clk); lines[3] = 1'b0; lines[4] = 1'b0; settle();
    wr(D | 13'h284, 32'hFFFF_FFFF);

    // R11 software trigger
    wr(D | 13'hF00, 50);
    rd(D | 13'h204, v); chk("R11 soft trigger", v, 32'h4_0000);
    wr(D | 13'h284, 32'hFFFF_FFFF);

    // R12 info
    rd(D | 13'h004, v); chk("R12 groups", v, 1);
    rd(D | 13'hFE0, v); chk("R12 ident0", v, {24'b0, IDV[7:0]});
    rd(D | 13'hFFC, v); chk("R12 ident7", v, {24'b0, IDV[63:56]});
    rd(D | 13'h804, v); chk("R10 targets", v, 32'h0101_0101);

    // R13 undefined
    chk("R13 err before", {31'b0, err}, 0);
    wr(D | 13'h108, 32'hFFFF_FFFF);
    chk("R13 err set", {31'b0, err}, 1);
    rd(D | 13'h100, v); chk("R13 write ignored", v, 32'h7FFF);
    rd(D | 13'h108, v); chk("R13 reads zero", v, 0);
    rd(13'h01C, v); chk("R13 cpu undefined zero", v, 0);
    chk("R13 err sticky", {31'b0, err}, 1);

    // random rounds: R2 R4 R5 R9
    for (int i = 0; i < N; i++) m_pend[i] = 0;
    for (int it = 0; it < 24; it++) begin
      logic [31:0] r;
      wr(D | 13'h280, 32'hFFFF_FFFF);
      wr(D | 13'h284, 32'hFFFF_FFFF);
      for (int i = 0; i < N; i++) m_pend[i] = 0;
      r = $urandom;
      wr(D | 13'h104, r); wr(D | 13'h184, ~r);
      for (int b = 0; b < 32; b++) m_en[32+b] = r[b];
      rd(D | 13'h104, v); chk("R9 enable word", v, r);
      for (int k = 0; k < 8; k++) begin
        logic [31:0] p;
        for (int j = 0; j < 4; j++) begin
          p[8*j +: 8] = 8'(($urandom % 6) << 5);
          m_prio[32 + 4*k + j] = p[8*j +: 8];
        end
        wr(D | (13'h420 + 13'(4*k)), p);
      end
      r = $urandom;
      wr(D | 13'h204, r);
      for (int b = 0; b < 32; b++) m_pend[32+b] = r[b];
      m = int'(($urandom % 6) << 5);
      wr(13'h004, 32'(m));
      e = exp_best(m);
      rd(13'h018, v); chk("R2 random hp", v, 32'(e));
      chk("R2 random irq", {31'b0, irq}, {31'b0, e != 1023});
      rd(13'h00C, v); chk("R4 random ack", v, 32'(e));
      if (e != 1023) begin
        m_pend[e] = 0;
        wr(13'h010, 32'(e));
        rd(13'h014, v); chk("R5 random retire", v, 32'h100);
      end
      rd(D | 13'h204, v);
      begin
        logic [31:0] ep;
        for (int b = 0; b < 32; b++) ep[b] = m_pend[32+b];
        chk("R9 pending word", v, ep);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule